// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Back Data Cache

This block is a small data cache. It sits between a processor-side word port and a memory-side block port. The processor issues one 32-bit read or write at a time through a valid/ready handshake. The cache accepts the request and splits its address into a tag, a set index and a word select. It then compares the stored tags of both ways of the selected set in the same cycle. On a hit, it answers from the matching way. On a miss, it brings the whole 32-byte block in from memory.

Stores change only the cached copy and mark the line dirty. A dirty line goes back to memory only when it is chosen as a victim. That writeback always comes before the refill read for the new block. Each set keeps one least-recently-used bit, and this bit picks the victim when both ways hold valid lines. A separate invalidate-all input drops every line without writing any of them back.

Top module: `cache2w_wb`

## Requirements
- R1: Address bits [31:9] are the tag, bits [8:5] select one of 16 sets, and bits [4:2] select one of eight 32-bit words in the block. Both ways of the set are compared at once, and a hit is presented on `cpu_rsp_valid` in the cycle after the first clock edge following acceptance.
- R2: A read hit returns the addressed word of the way whose valid tag matched.
- R3: A miss fetches the whole block with a memory read at the block-aligned address (bits [4:0] zero). When memory accepts at once and answers in the cycle after the handshake, a miss with a clean or empty victim responds after the fourth edge following acceptance.
- R4: On a miss, an invalid way is filled first, with way 0 before way 1. When both ways are valid, the least-recently-used way is replaced. Every hit, including the lookup that completes a refill, marks the way just used as most recent.
- R5: A write hit updates only the cached word and marks the line dirty. It causes no memory request, and a later read returns the new value.
- R6: When the victim is valid and dirty, the cache first issues a memory write carrying the victim's block address and full contents. It then issues the refill read. This adds one edge, so the response follows the fifth edge after acceptance.
- R7: A write miss allocates the block. It fetches the block, merges the write word into it and leaves the line dirty, so later reads of that word hit and return the written data. The other words of the block keep their memory values.
- R8: While `inval_all` is high, no request is accepted. On the next idle edge every valid bit clears and nothing is written back, so dirty data is dropped.
- R9: Only one request is outstanding. `cpu_req_ready` falls after acceptance and stays low until the response, and `cpu_rsp_valid` is a single-cycle pulse.
- R10: A memory request that is not accepted stays asserted with an unchanged address and direction until `mem_req_ready` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inval_all | input | 1 | Drop all lines without writeback |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_ready | output | 1 | Cache can accept a request |
| cpu_req_we | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | 32 | Byte address of the word |
| cpu_req_wdata | input | 32 | Write word |
| cpu_rsp_valid | output | 1 | One-cycle completion pulse |
| cpu_rsp_rdata | output | 32 | Read word (for writes: the word before the update) |
| mem_req_valid | output | 1 | Block request present |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_we | output | 1 | 1 = block writeback, 0 = block fetch |
| mem_req_addr | output | 32 | Block-aligned address |
| mem_req_wdata | output | 256 | Writeback block contents |
| mem_rsp_valid | input | 1 | Fetched block present |
| mem_rsp_rdata | input | 256 | Fetched block contents |

## Verification
Each access is timed in clock edges counted from the edge that accepts it. A hit completes after 1 edge, a clean or empty-victim miss after 4, and a miss that has to write back a dirty victim after 5. The bench memory model accepts at once and answers one cycle after the handshake. The bench samples at the falling edge, counts the edges until the response pulse and compares that count with the figure above. In the stalled-memory scenario the count is left open, and the bench instead checks at every falling edge that the held request stays unchanged.

// File: rtl/cache2w_pkg.sv
package cache2w_pkg;
    localparam int ADDR_W   = 32;
    localparam int WORD_W   = 32;
    localparam int OFF_W    = 5;
    localparam int IDX_W    = 4;
    localparam int NUM_WAYS = 2;
    localparam int SETS     = 1 << IDX_W;
    localparam int BLK_W    = 8 * (1 << OFF_W);
    localparam int WORDS    = BLK_W / WORD_W;
    localparam int WSEL_W   = $clog2(WORDS);
    localparam int BSEL_W   = OFF_W - WSEL_W;
    localparam int TAG_W    = ADDR_W - IDX_W - OFF_W;

    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [WSEL_W-1:0] wsel_t;
    typedef logic [WORD_W-1:0] word_t;
    typedef logic [BLK_W-1:0]  blk_t;
    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic              way_t;

    typedef struct packed {
        logic  we;
        addr_t addr;
        word_t wdata;
    } cpu_req_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_WRBACK,
        ST_FETCH,
        ST_WAIT
    } cstate_t;

    function automatic tag_t addr_tag(input addr_t a);
        return a[ADDR_W-1 -: TAG_W];
    endfunction

    function automatic idx_t addr_idx(input addr_t a);
        return a[OFF_W +: IDX_W];
    endfunction

    function automatic wsel_t addr_wsel(input addr_t a);
        return a[BSEL_W +: WSEL_W];
    endfunction

    function automatic addr_t blk_addr(input tag_t t, input idx_t i);
        return {t, i, {OFF_W{1'b0}}};
    endfunction
endpackage

// File: rtl/cache2w_tag_store.sv
module cache2w_tag_store
    import cache2w_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                clear_all,
    input  idx_t                idx,
    input  logic                fill_en,
    input  way_t                fill_way,
    input  tag_t                fill_tag,
    input  logic                dirty_en,
    input  way_t                dirty_way,
    input  logic                lru_en,
    input  way_t                lru_used,
    output logic [NUM_WAYS-1:0] way_valid,
    output logic [NUM_WAYS-1:0] way_dirty,
    output tag_t                way_tag [NUM_WAYS],
    output way_t                lru_victim
);
    logic [SETS-1:0] lru_q;

    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
        logic [SETS-1:0] valid_q;
        logic [SETS-1:0] dirty_q;
        tag_t            tag_q [SETS];
        logic            sel_fill;
        logic            sel_dirty;

        assign sel_fill  = fill_en  && (fill_way  == way_t'(w));
        assign sel_dirty = dirty_en && (dirty_way == way_t'(w));

        always_ff @(posedge clk) begin
            if (rst) begin
                valid_q <= '0;
                dirty_q <= '0;
            end else begin
                if (clear_all) begin
                    valid_q <= '0;
                end else if (sel_fill) begin
                    valid_q[idx] <= 1'b1;
                end
                if (sel_fill) begin
                    dirty_q[idx] <= 1'b0;
                end else if (sel_dirty) begin
                    dirty_q[idx] <= 1'b1;
                end
            end
        end

        always_ff @(posedge clk) begin
            if (sel_fill) begin
                tag_q[idx] <= fill_tag;
            end
        end

        assign way_valid[w] = valid_q[idx];
        assign way_dirty[w] = dirty_q[idx];
        assign way_tag[w]   = tag_q[idx];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lru_q <= '0;
        end else if (lru_en) begin
            lru_q[idx] <= ~lru_used;
        end
    end

    assign lru_victim = lru_q[idx];
endmodule

// File: rtl/cache2w_data_store.sv
module cache2w_data_store
    import cache2w_pkg::*;
(
    input  logic  clk,
    input  idx_t  idx,
    input  logic  fill_en,
    input  way_t  fill_way,
    input  blk_t  fill_blk,
    input  logic  word_we,
    input  way_t  word_way,
    input  wsel_t word_sel,
    input  word_t word_data,
    output blk_t  way_blk [NUM_WAYS]
);
    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
        blk_t blk_q [SETS];

        always_ff @(posedge clk) begin
            if (fill_en && fill_way == way_t'(w)) begin
                blk_q[idx] <= fill_blk;
            end else if (word_we && word_way == way_t'(w)) begin
                blk_q[idx][word_sel*WORD_W +: WORD_W] <= word_data;
            end
        end

        assign way_blk[w] = blk_q[idx];
    end
endmodule

// File: rtl/cache2w_way_match.sv
module cache2w_way_match
    import cache2w_pkg::*;
(
    input  logic [NUM_WAYS-1:0] way_valid,
    input  tag_t                way_tag [NUM_WAYS],
    input  tag_t                req_tag,
    output logic                hit,
    output way_t                hit_way
);
    logic [NUM_WAYS-1:0] match;

    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_cmp
        assign match[w] = way_valid[w] && (way_tag[w] == req_tag);
    end

    always_comb begin
        hit     = |match;
        hit_way = 1'b0;
        for (int w = NUM_WAYS - 1; w >= 0; w--) begin
            if (match[w]) begin
                hit_way = way_t'(w);
            end
        end
    end
endmodule

// File: rtl/cache2w_wb.sv
module cache2w_wb
    import cache2w_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         inval_all,
    input  logic         cpu_req_valid,
    output logic         cpu_req_ready,
    input  logic         cpu_req_we,
    input  logic [31:0]  cpu_req_addr,
    input  logic [31:0]  cpu_req_wdata,
    output logic         cpu_rsp_valid,
    output logic [31:0]  cpu_rsp_rdata,
    output logic         mem_req_valid,
    input  logic         mem_req_ready,
    output logic         mem_req_we,
    output logic [31:0]  mem_req_addr,
    output logic [255:0] mem_req_wdata,
    input  logic         mem_rsp_valid,
    input  logic [255:0] mem_rsp_rdata
);
    cstate_t  state_q, state_d;
    cpu_req_t req_q;
    way_t     victim_q, victim_d;

    tag_t  r_tag;
    idx_t  r_idx;
    wsel_t r_wsel;

    logic [NUM_WAYS-1:0] way_valid, way_dirty;
    tag_t                way_tag [NUM_WAYS];
    blk_t                way_blk [NUM_WAYS];
    way_t                lru_victim;
    logic                hit;
    way_t                hit_way;
    way_t                pick_way;

    logic  in_lookup, lookup_hit, accept, clear_now;
    logic  fill_en;
    word_t hit_word;

    assign r_tag  = addr_tag(req_q.addr);
    assign r_idx  = addr_idx(req_q.addr);
    assign r_wsel = addr_wsel(req_q.addr);

    assign cpu_req_ready = (state_q == ST_IDLE) && !inval_all;
    assign accept        = cpu_req_valid && cpu_req_ready;
    assign clear_now     = inval_all && (state_q == ST_IDLE);
    assign in_lookup     = (state_q == ST_LOOKUP);
    assign lookup_hit    = in_lookup && hit;
    assign fill_en       = (state_q == ST_WAIT) && mem_rsp_valid;
    assign hit_word      = way_blk[hit_way][r_wsel*WORD_W +: WORD_W];

    cache2w_way_match u_match (
        .way_valid (way_valid),
        .way_tag   (way_tag),
        .req_tag   (r_tag),
        .hit       (hit),
        .hit_way   (hit_way)
    );

    cache2w_tag_store u_tags (
        .clk        (clk),
        .rst        (rst),
        .clear_all  (clear_now),
        .idx        (r_idx),
        .fill_en    (fill_en),
        .fill_way   (victim_q),
        .fill_tag   (r_tag),
        .dirty_en   (lookup_hit && req_q.we),
        .dirty_way  (hit_way),
        .lru_en     (lookup_hit),
        .lru_used   (hit_way),
        .way_valid  (way_valid),
        .way_dirty  (way_dirty),
        .way_tag    (way_tag),
        .lru_victim (lru_victim)
    );

    cache2w_data_store u_data (
        .clk       (clk),
        .idx       (r_idx),
        .fill_en   (fill_en),
        .fill_way  (victim_q),
        .fill_blk  (mem_rsp_rdata),
        .word_we   (lookup_hit && req_q.we),
        .word_way  (hit_way),
        .word_sel  (r_wsel),
        .word_data (req_q.wdata),
        .way_blk   (way_blk)
    );

    // empty ways first (lowest number wins), otherwise the per-set LRU choice
    always_comb begin
        if (!way_valid[0]) begin
            pick_way = 1'b0;
        end else if (!way_valid[1]) begin
            pick_way = 1'b1;
        end else begin
            pick_way = lru_victim;
        end
    end

    always_comb begin
        state_d  = state_q;
        victim_d = victim_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    state_d = ST_LOOKUP;
                end
            end
            ST_LOOKUP: begin
                if (hit) begin
                    state_d = ST_IDLE;
                end else begin
                    victim_d = pick_way;
                    if (way_valid[pick_way] && way_dirty[pick_way]) begin
                        state_d = ST_WRBACK;
                    end else begin
                        state_d = ST_FETCH;
                    end
                end
            end
            ST_WRBACK: begin
                if (mem_req_ready) begin
                    state_d = ST_FETCH;
                end
            end
            ST_FETCH: begin
                if (mem_req_ready) begin
                    state_d = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (mem_rsp_valid) begin
                    state_d = ST_LOOKUP;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        mem_req_valid = 1'b0;
        mem_req_we    = 1'b0;
        mem_req_addr  = blk_addr(r_tag, r_idx);
        mem_req_wdata = way_blk[victim_q];
        if (state_q == ST_WRBACK) begin
            mem_req_valid = 1'b1;
            mem_req_we    = 1'b1;
            mem_req_addr  = blk_addr(way_tag[victim_q], r_idx);
        end else if (state_q == ST_FETCH) begin
            mem_req_valid = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q       <= ST_IDLE;
            victim_q      <= 1'b0;
            req_q         <= '0;
            cpu_rsp_valid <= 1'b0;
            cpu_rsp_rdata <= '0;
        end else begin
            state_q       <= state_d;
            victim_q      <= victim_d;
            cpu_rsp_valid <= lookup_hit;
            if (accept) begin
                req_q <= '{we: cpu_req_we, addr: cpu_req_addr, wdata: cpu_req_wdata};
            end
            if (lookup_hit) begin
                cpu_rsp_rdata <= hit_word;
            end
        end
    end
endmodule

// File: rtl/cache2w_wb_chk.sv
module cache2w_wb_chk (
    input logic        clk,
    input logic        rst,
    input logic        inval_all,
    input logic        cpu_req_valid,
    input logic        cpu_req_ready,
    input logic        cpu_rsp_valid,
    input logic        mem_req_valid,
    input logic        mem_req_ready,
    input logic        mem_req_we,
    input logic [31:0] mem_req_addr
);
    p_rsp_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        cpu_rsp_valid |=> !cpu_rsp_valid);

    p_busy_after_accept_r9: assert property (@(posedge clk) disable iff (rst)
        (cpu_req_valid && cpu_req_ready) |=> !cpu_req_ready);

    p_inval_blocks_r8: assert property (@(posedge clk) disable iff (rst)
        inval_all |-> !cpu_req_ready);

    p_block_align_r3: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> (mem_req_addr[4:0] == 5'd0));

    p_hold_req_r10: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we)));

    p_wb_then_fetch_r6: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && mem_req_ready && mem_req_we) |=> (mem_req_valid && !mem_req_we));

    p_idle_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        cpu_req_ready |-> !mem_req_valid);
endmodule

bind cache2w_wb cache2w_wb_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .inval_all     (inval_all),
    .cpu_req_valid (cpu_req_valid),
    .cpu_req_ready (cpu_req_ready),
    .cpu_rsp_valid (cpu_rsp_valid),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_we    (mem_req_we),
    .mem_req_addr  (mem_req_addr)
);

// File: tb/tb_cache2w_wb.sv
module tb_cache2w_wb;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         inval_all = 1'b0;
    logic         cpu_req_valid = 1'b0;
    logic         cpu_req_ready;
    logic         cpu_req_we = 1'b0;
    logic [31:0]  cpu_req_addr = '0;
    logic [31:0]  cpu_req_wdata = '0;
    logic         cpu_rsp_valid;
    logic [31:0]  cpu_rsp_rdata;
    logic         mem_req_valid;
    logic         mem_req_ready;
    logic         mem_req_we;
    logic [31:0]  mem_req_addr;
    logic [255:0] mem_req_wdata;
    logic         mem_rsp_valid;
    logic [255:0] mem_rsp_rdata;

    logic         hold_mem = 1'b0;
    int           n_chk = 0;
    int           n_fail = 0;
    int           rd_cnt, wb_cnt;
    logic [31:0]  last_wb_addr;
    logic [255:0] last_wb_data;
    logic [255:0] mem_store [256];
    logic         mem_wr [256];

    localparam logic [31:0] A = 32'h0001_0020;
    localparam logic [31:0] B = 32'h0002_0020;
    localparam logic [31:0] C = 32'h0003_0020;
    localparam logic [31:0] D = 32'h0004_0060;
    localparam logic [31:0] E = 32'h0005_00A0;

    always #5 clk = ~clk;

    assign mem_req_ready = !hold_mem;

    cache2w_wb dut (
        .clk(clk), .rst(rst), .inval_all(inval_all),
        .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
        .cpu_req_we(cpu_req_we), .cpu_req_addr(cpu_req_addr), .cpu_req_wdata(cpu_req_wdata),
        .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_rdata(cpu_rsp_rdata),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata)
    );

    function automatic logic [31:0] dflt_word(input logic [31:0] a);
        return {a[31:2], 2'b00} ^ 32'hC0DE_0000;
    endfunction

    function automatic logic [255:0] dflt_block(input logic [31:0] a);
        logic [255:0] b;
        for (int w = 0; w < 8; w++) begin
            b[w*32 +: 32] = dflt_word({a[31:5], 3'(w), 2'b00});
        end
        return b;
    endfunction

    // memory model: accepts when ready, answers a fetch one cycle after the handshake
    always @(posedge clk) begin
        mem_rsp_valid <= 1'b0;
        if (rst) begin
            rd_cnt <= 0;
            wb_cnt <= 0;
            last_wb_addr <= '0;
            last_wb_data <= '0;
            for (int k = 0; k < 256; k++) mem_wr[k] <= 1'b0;
        end else if (mem_req_valid && mem_req_ready) begin
            if (mem_req_we) begin
                mem_store[mem_req_addr[19:12]] <= mem_req_wdata;
                mem_wr[mem_req_addr[19:12]]    <= 1'b1;
                wb_cnt       <= wb_cnt + 1;
                last_wb_addr <= mem_req_addr;
                last_wb_data <= mem_req_wdata;
            end else begin
                rd_cnt        <= rd_cnt + 1;
                mem_rsp_valid <= 1'b1;
                mem_rsp_rdata <= mem_wr[mem_req_addr[19:12]] ? mem_store[mem_req_addr[19:12]]
                                                               : dflt_block(mem_req_addr);
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic access(input logic we, input logic [31:0] addr, input logic [31:0] wd,
                          input int exp_lat, input bit chk_data, input logic [31:0] exp_data,
                          input string req);
        int lat = 0;
        @(negedge clk);
        chk(cpu_req_ready, req, "ready before request", 32'(cpu_req_ready), 32'd1);
        cpu_req_valid = 1'b1;
        cpu_req_we    = we;
        cpu_req_addr  = addr;
        cpu_req_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        cpu_req_valid = 1'b0;
        for (;;) begin
            if (lat > 0 && cpu_rsp_valid) break;
            if (lat > 40) break;
            @(posedge clk);
            lat++;
            @(negedge clk);
        end
        chk(lat == exp_lat, req, "latency", 32'(lat), 32'(exp_lat));
        if (chk_data) chk(cpu_rsp_rdata == exp_data, req, "read data", cpu_rsp_rdata, exp_data);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(cpu_req_ready == 1'b1, "R9", "reset ready", 32'(cpu_req_ready), 32'd1);
        chk(cpu_rsp_valid == 1'b0, "R9", "reset rsp_valid", 32'(cpu_rsp_valid), 32'd0);
        chk(mem_req_valid == 1'b0, "R3", "reset mem_req_valid", 32'(mem_req_valid), 32'd0);
    endtask

    task automatic t_read_miss();
        access(1'b0, A, '0, 4, 1'b1, dflt_word(A), "R3");
        chk(rd_cnt == 1, "R3", "one block fetch", 32'(rd_cnt), 32'd1);
        chk(wb_cnt == 0, "R3", "no writeback", 32'(wb_cnt), 32'd0);
    endtask

    task automatic t_read_hit();
        access(1'b0, A + 8, '0, 1, 1'b1, dflt_word(A + 8), "R1");
        access(1'b0, A + 28, '0, 1, 1'b1, dflt_word(A + 28), "R2");
    endtask

    task automatic t_write_hit();
        int r0 = rd_cnt;
        int w0 = wb_cnt;
        access(1'b1, A + 4, 32'h1234_5678, 1, 1'b0, '0, "R5");
        access(1'b0, A + 4, '0, 1, 1'b1, 32'h1234_5678, "R5");
        chk(rd_cnt == r0 && wb_cnt == w0, "R5", "no memory traffic", 32'(rd_cnt + wb_cnt), 32'(r0 + w0));
    endtask

    task automatic t_lru_and_writeback();
        int w0 = wb_cnt;
        access(1'b0, B, '0, 4, 1'b1, dflt_word(B), "R4");
        access(1'b0, A, '0, 1, 1'b1, dflt_word(A), "R4");
        access(1'b0, C, '0, 4, 1'b1, dflt_word(C), "R4");
        chk(wb_cnt == w0, "R4", "clean LRU victim chosen", 32'(wb_cnt), 32'(w0));
        access(1'b0, B, '0, 5, 1'b1, dflt_word(B), "R6");
        chk(wb_cnt == w0 + 1, "R6", "one writeback", 32'(wb_cnt), 32'(w0 + 1));
        chk(last_wb_addr == A, "R6", "writeback address", last_wb_addr, A);
        chk(last_wb_data[63:32] == 32'h1234_5678, "R6", "writeback dirty word",
            last_wb_data[63:32], 32'h1234_5678);
        chk(last_wb_data[31:0] == dflt_word(A), "R6", "writeback clean word",
            last_wb_data[31:0], dflt_word(A));
        access(1'b0, A + 4, '0, 4, 1'b1, 32'h1234_5678, "R4");
        access(1'b0, B, '0, 1, 1'b1, dflt_word(B), "R4");
    endtask

    task automatic t_write_miss();
        access(1'b1, D + 8, 32'hDEAD_BEEF, 4, 1'b0, '0, "R7");
        access(1'b0, D + 8, '0, 1, 1'b1, 32'hDEAD_BEEF, "R7");
        access(1'b0, D + 12, '0, 1, 1'b1, dflt_word(D + 12), "R7");
    endtask

    task automatic t_invalidate();
        int w0 = wb_cnt;
        @(negedge clk);
        inval_all = 1'b1;
        #1;
        chk(cpu_req_ready == 1'b0, "R8", "ready low during invalidate", 32'(cpu_req_ready), 32'd0);
        @(posedge clk);
        @(negedge clk);
        inval_all = 1'b0;
        access(1'b0, D + 8, '0, 4, 1'b1, dflt_word(D + 8), "R8");
        access(1'b0, B, '0, 4, 1'b1, dflt_word(B), "R8");
        chk(wb_cnt == w0, "R8", "no writeback on invalidate", 32'(wb_cnt), 32'(w0));
    endtask

    task automatic t_stall();
        bit steady = 1'b1;
        int n = 0;
        hold_mem = 1'b1;
        @(negedge clk);
        cpu_req_valid = 1'b1;
        cpu_req_we    = 1'b0;
        cpu_req_addr  = E;
        @(posedge clk);
        @(negedge clk);
        cpu_req_valid = 1'b0;
        for (int k = 0; k < 4; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (!(mem_req_valid && !mem_req_we && mem_req_addr == E)) steady = 1'b0;
        end
        chk(steady, "R10", "request held while stalled", mem_req_addr, E);
        hold_mem = 1'b0;
        while (!cpu_rsp_valid && n < 40) begin
            @(posedge clk);
            @(negedge clk);
            n++;
        end
        chk(cpu_rsp_valid && cpu_rsp_rdata == dflt_word(E), "R10", "data after stall",
            cpu_rsp_rdata, dflt_word(E));
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_read_miss();
        t_read_hit();
        t_write_hit();
        t_lru_and_writeback();
        t_write_miss();
        t_invalidate();
        t_stall();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule